// File: doc/BRIEF.md
# DRAM Command Timing Legality Checker

This block sits beside a memory controller's command path and audits the stream of already-decoded DRAM commands, one per clock. Each command carries an opcode (activate, read, write, read with auto-precharge, precharge of one bank, precharge of all banks, refresh, or deselect) and a bank number for an eight-bank device. For every bank it keeps down-counters for the minimum spacings between commands. It also keeps two device-wide counters: one for activate-to-activate spacing across banks and one for refresh recovery. Any command issued before its spacing has elapsed is reported.

Spacing limits are clock counts, already rounded up from nanoseconds. They come from a configuration port that is captured on every clock while reset is held low and frozen once reset is released. A violation produces a one-cycle flag with a rule code and the bank field of the offending command. The flag appears in the cycle after the command is accepted. The offending command still updates the timing state as if it were legal, so later checks refer to what the device actually received.

The command input is a valid/ready stream with no back-pressure in operation. `cmd_ready` is low while reset is asserted and high at all other times. A command counts only in a cycle where `cmd_valid` and `cmd_ready` are both high. A cycle without an accepted command, or with the deselect opcode, only lets time pass.

Top module: `dram_cmd_timing_checker`

## Requirements
- R1: While `rst_n` is low the six limit inputs are captured and all counters clear; after release the captured limits stay fixed, and the first cycle after release shows `viol_valid`=0 and `cmd_ready`=1.
- R2: A read (op 2), write (op 3) or read with auto-precharge (op 7) to a bank fewer than `cfg_rcd_cycles` cycles after that bank's activate (op 1) raises rule code 1; exactly that many cycles later it is legal.
- R3: A precharge (op 4) to a bank fewer than `cfg_ras_cycles` cycles after its activate raises rule code 2; exactly that many cycles later it is legal.
- R4: An activate to a bank fewer than `cfg_rc_cycles` cycles after the previous activate to the same bank raises rule code 3.
- R5: An activate to a bank other than the most recently activated one, fewer than `cfg_rrd_cycles` cycles after that activate, raises rule code 4.
- R6: An activate to a bank fewer than `cfg_rp_cycles` cycles after a precharge of that bank raises rule code 5.
- R7: Precharge-all (op 5) demands `cfg_rp_cycles`+1 cycles before any bank may be activated (rule code 5), and it raises rule code 2 if any bank is still within its minimum active time.
- R8: After a read with auto-precharge, the bank closes internally in the later of the following cycle and the first cycle its minimum active time has elapsed; an activate before `cfg_rp_cycles` cycles past that point raises rule code 5.
- R9: An activate or refresh (op 6) fewer than `cfg_rfc_cycles` cycles after a refresh raises rule code 6.
- R10: When several rules are broken by one command, a single code is reported, chosen in the order 6, 5, 3, 4, 2, 1 (highest first).
- R11: A violation drives `viol_valid` high for the one cycle after the command is accepted, with `viol_rule` nonzero and `viol_bank` equal to the command's bank field; the offending command still updates the timing state.
- R12: A deselect (op 0), or a cycle with `cmd_valid` low, never raises a violation and does not update any timing state.
- R13: `cmd_ready` is low during reset; a command presented while `cmd_valid` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous capture of limits, asynchronous clear of counters; active low |
| cfg_rcd_cycles | input | 8 | Activate to read/write spacing, clocks |
| cfg_ras_cycles | input | 8 | Minimum row-open time, clocks |
| cfg_rc_cycles | input | 8 | Same-bank activate spacing, clocks |
| cfg_rrd_cycles | input | 8 | Cross-bank activate spacing, clocks |
| cfg_rp_cycles | input | 8 | Precharge to activate spacing, clocks |
| cfg_rfc_cycles | input | 8 | Refresh recovery time, clocks |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted when high |
| cmd_op | input | 3 | Opcode: 0 deselect, 1 activate, 2 read, 3 write, 4 precharge, 5 precharge-all, 6 refresh, 7 read with auto-precharge |
| cmd_bank | input | 3 | Target bank |
| viol_valid | output | 1 | One-cycle violation strobe |
| viol_rule | output | 3 | Broken rule: 1 rcd, 2 ras, 3 rc, 4 rrd, 5 rp, 6 rfc, 0 none |
| viol_bank | output | 3 | Bank field of the offending command |

## Verification
A wrong counter value or a stale auto-precharge flag inside a bank stays hidden until the next command that consults it. It then shows as a missing or spurious strobe one cycle after that command. Because an off-by-one load only changes the outcome at a single cycle, the stimulus places commands both one cycle short of each limit and exactly at it. The precharge-all penalty and the auto-precharge close point are probed on the one cycle where they differ from the plain precharge case. The priority order is exercised by commands that break two rules at once, and the stream handshake by activates presented with `cmd_valid` low just before a spacing-sensitive activate.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  typedef enum logic [2:0] {
    CMD_DESEL = 3'd0,
    CMD_ACT   = 3'd1,
    CMD_RD    = 3'd2,
    CMD_WR    = 3'd3,
    CMD_PRE   = 3'd4,
    CMD_PREA  = 3'd5,
    CMD_REF   = 3'd6,
    CMD_RDA   = 3'd7
  } dram_cmd_e;

  typedef enum logic [2:0] {
    RULE_NONE = 3'd0,
    RULE_RCD  = 3'd1,
    RULE_RAS  = 3'd2,
    RULE_RC   = 3'd3,
    RULE_RRD  = 3'd4,
    RULE_RP   = 3'd5,
    RULE_RFC  = 3'd6
  } rule_e;

  localparam int NUM_RULES = 6;
  // hit vector bit index for each rule; higher index wins
  localparam int HIT_RCD = 0;
  localparam int HIT_RAS = 1;
  localparam int HIT_RRD = 2;
  localparam int HIT_RC  = 3;
  localparam int HIT_RP  = 4;
  localparam int HIT_RFC = 5;
endpackage

// File: rtl/dtc_cfg_latch.sv
module dtc_cfg_latch #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] rcd_i,
  input  logic [CNT_W-1:0] ras_i,
  input  logic [CNT_W-1:0] rc_i,
  input  logic [CNT_W-1:0] rrd_i,
  input  logic [CNT_W-1:0] rp_i,
  input  logic [CNT_W-1:0] rfc_i,
  output logic [CNT_W-1:0] rcd_o,
  output logic [CNT_W-1:0] ras_o,
  output logic [CNT_W-1:0] rc_o,
  output logic [CNT_W-1:0] rrd_o,
  output logic [CNT_W-1:0] rp_o,
  output logic [CNT_W-1:0] rfc_o
);
  // limits follow the port while reset is held, then freeze
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rcd_o <= rcd_i;
      ras_o <= ras_i;
      rc_o  <= rc_i;
      rrd_o <= rrd_i;
      rp_o  <= rp_i;
      rfc_o <= rfc_i;
    end
  end

  a_r1_limits_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ($stable(rcd_o) && $stable(ras_o) && $stable(rc_o) &&
               $stable(rrd_o) && $stable(rp_o) && $stable(rfc_o)));
endmodule

// File: rtl/dtc_bank_timer.sv
module dtc_bank_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] trcd_i,
  input  logic [CNT_W-1:0] tras_i,
  input  logic [CNT_W-1:0] trc_i,
  input  logic [CNT_W-1:0] trp_i,
  input  logic             act_i,
  input  logic             pre_i,
  input  logic             prea_i,
  input  logic             rda_i,
  output logic             rcd_busy_o,
  output logic             ras_busy_o,
  output logic             rc_busy_o,
  output logic             rp_busy_o
);
  logic [CNT_W-1:0] rcd_q, ras_q, rc_q, rp_q;
  logic             ap_pend_q;
  logic             ap_fire;

  // a limit of L cycles is stored as L-1 so that zero means "allowed now"
  function automatic logic [CNT_W-1:0] lim_to_cnt(input logic [CNT_W-1:0] lim);
    return (lim == '0) ? '0 : lim - 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] tick(input logic [CNT_W-1:0] c);
    return (c == '0) ? '0 : c - 1'b1;
  endfunction

  // internal close of an auto-precharged row waits for the active time
  assign ap_fire = ap_pend_q && (ras_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcd_q     <= '0;
      ras_q     <= '0;
      rc_q      <= '0;
      rp_q      <= '0;
      ap_pend_q <= 1'b0;
    end else begin
      rcd_q <= act_i ? lim_to_cnt(trcd_i) : tick(rcd_q);
      ras_q <= act_i ? lim_to_cnt(tras_i) : tick(ras_q);
      rc_q  <= act_i ? lim_to_cnt(trc_i)  : tick(rc_q);

      if (prea_i)                rp_q <= trp_i;  // one extra clock
      else if (pre_i || ap_fire) rp_q <= lim_to_cnt(trp_i);
      else                       rp_q <= tick(rp_q);

      if (act_i || pre_i || prea_i) ap_pend_q <= 1'b0;
      else if (rda_i)               ap_pend_q <= 1'b1;
      else if (ap_fire)             ap_pend_q <= 1'b0;
    end
  end

  assign rcd_busy_o = (rcd_q != '0);
  assign ras_busy_o = (ras_q != '0);
  assign rc_busy_o  = (rc_q  != '0);
  assign rp_busy_o  = (rp_q  != '0) || ap_pend_q;

  a_r4_rc_armed: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i && (trc_i > CNT_W'(1))) |=> rc_busy_o);

  a_r6_pre_blocks_act: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_i && (trp_i > CNT_W'(1))) |=> rp_busy_o);

  a_r8_ap_held_by_ras: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_pend_q && ras_busy_o && !act_i && !pre_i && !prea_i) |=> ap_pend_q);

  a_r3_ras_never_grows: assert property (@(posedge clk) disable iff (!rst_n)
    !act_i |=> (ras_q <= $past(ras_q)));
endmodule

// File: rtl/dtc_global_timer.sv
module dtc_global_timer #(
  parameter int NUM_BANKS = 8,
  parameter int CNT_W     = 8,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  trrd_i,
  input  logic [CNT_W-1:0]  trfc_i,
  input  logic              act_i,
  input  logic              ref_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic              rrd_busy_o,
  output logic              rfc_busy_o
);
  logic [CNT_W-1:0]  rrd_q, rfc_q;
  logic [BANK_W-1:0] last_bank_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rrd_q       <= '0;
      rfc_q       <= '0;
      last_bank_q <= '0;
    end else begin
      if (act_i) begin
        rrd_q       <= (trrd_i == '0) ? '0 : trrd_i - 1'b1;
        last_bank_q <= bank_i;
      end else if (rrd_q != '0) begin
        rrd_q <= rrd_q - 1'b1;
      end
      if (ref_i)              rfc_q <= (trfc_i == '0) ? '0 : trfc_i - 1'b1;
      else if (rfc_q != '0)   rfc_q <= rfc_q - 1'b1;
    end
  end

  // cross-bank spacing only; the same bank is governed by its own cycle time
  assign rrd_busy_o = (rrd_q != '0) && (bank_i != last_bank_q);
  assign rfc_busy_o = (rfc_q != '0);

  a_r9_rfc_armed: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_i && (trfc_i > CNT_W'(1))) |=> rfc_busy_o);

  a_r5_last_bank_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    act_i |=> (last_bank_q == $past(bank_i)));
endmodule

// File: rtl/dtc_rule_select.sv
module dtc_rule_select #(
  parameter int NUM_BANKS = 8,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [dtc_pkg::NUM_RULES-1:0] hit_i,
  input  logic [BANK_W-1:0]             bank_i,
  output logic                          viol_o,
  output logic [2:0]                    rule_o,
  output logic [BANK_W-1:0]             bank_o
);
  import dtc_pkg::*;

  // bit r of the hit vector maps to a rule code; later bits override earlier
  function automatic logic [2:0] code_of(input int idx);
    case (idx)
      HIT_RCD: return RULE_RCD;
      HIT_RAS: return RULE_RAS;
      HIT_RRD: return RULE_RRD;
      HIT_RC:  return RULE_RC;
      HIT_RP:  return RULE_RP;
      default: return RULE_RFC;
    endcase
  endfunction

  logic [2:0] pick;

  always_comb begin
    pick = RULE_NONE;
    for (int r = 0; r < NUM_RULES; r++) begin
      if (hit_i[r]) pick = code_of(r);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_o <= 1'b0;
      rule_o <= RULE_NONE;
      bank_o <= '0;
    end else begin
      viol_o <= (hit_i != '0);
      rule_o <= pick;
      bank_o <= (hit_i != '0) ? bank_i : '0;
    end
  end

  a_r11_code_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    viol_o |-> (rule_o != RULE_NONE));

  a_r11_quiet_code: assert property (@(posedge clk) disable iff (!rst_n)
    !viol_o |-> (rule_o == RULE_NONE));

  a_r10_refresh_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i[HIT_RFC] |=> (rule_o == RULE_RFC));

  a_r10_rp_over_rc: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i[HIT_RP] && !hit_i[HIT_RFC]) |=> (rule_o == RULE_RP));
endmodule

// File: rtl/dram_cmd_timing_checker.sv
module dram_cmd_timing_checker #(
  parameter int NUM_BANKS = 8,
  parameter int CNT_W     = 8,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cfg_rcd_cycles,
  input  logic [CNT_W-1:0]  cfg_ras_cycles,
  input  logic [CNT_W-1:0]  cfg_rc_cycles,
  input  logic [CNT_W-1:0]  cfg_rrd_cycles,
  input  logic [CNT_W-1:0]  cfg_rp_cycles,
  input  logic [CNT_W-1:0]  cfg_rfc_cycles,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [BANK_W-1:0] cmd_bank,
  output logic              viol_valid,
  output logic [2:0]        viol_rule,
  output logic [BANK_W-1:0] viol_bank
);
  import dtc_pkg::*;

  logic [CNT_W-1:0] trcd, tras, trc, trrd, trp, trfc;
  logic             accept;
  logic             is_act, is_col, is_pre, is_prea, is_ref, is_rda;
  logic [NUM_BANKS-1:0] rcd_busy, ras_busy, rc_busy, rp_busy;
  logic             rrd_busy, rfc_busy;
  logic [NUM_RULES-1:0] hit;

  assign cmd_ready = rst_n;
  assign accept    = cmd_valid && cmd_ready;

  assign is_act  = accept && (cmd_op == CMD_ACT);
  assign is_col  = accept && ((cmd_op == CMD_RD) || (cmd_op == CMD_WR) ||
                              (cmd_op == CMD_RDA));
  assign is_pre  = accept && (cmd_op == CMD_PRE);
  assign is_prea = accept && (cmd_op == CMD_PREA);
  assign is_ref  = accept && (cmd_op == CMD_REF);
  assign is_rda  = accept && (cmd_op == CMD_RDA);

  dtc_cfg_latch #(.CNT_W(CNT_W)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .rcd_i (cfg_rcd_cycles),
    .ras_i (cfg_ras_cycles),
    .rc_i  (cfg_rc_cycles),
    .rrd_i (cfg_rrd_cycles),
    .rp_i  (cfg_rp_cycles),
    .rfc_i (cfg_rfc_cycles),
    .rcd_o (trcd),
    .ras_o (tras),
    .rc_o  (trc),
    .rrd_o (trrd),
    .rp_o  (trp),
    .rfc_o (trfc)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = (cmd_bank == BANK_W'(b));

    dtc_bank_timer #(.CNT_W(CNT_W)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .trcd_i     (trcd),
      .tras_i     (tras),
      .trc_i      (trc),
      .trp_i      (trp),
      .act_i      (is_act && sel),
      .pre_i      (is_pre && sel),
      .prea_i     (is_prea),
      .rda_i      (is_rda && sel),
      .rcd_busy_o (rcd_busy[b]),
      .ras_busy_o (ras_busy[b]),
      .rc_busy_o  (rc_busy[b]),
      .rp_busy_o  (rp_busy[b])
    );
  end

  dtc_global_timer #(.NUM_BANKS(NUM_BANKS), .CNT_W(CNT_W)) u_glob (
    .clk        (clk),
    .rst_n      (rst_n),
    .trrd_i     (trrd),
    .trfc_i     (trfc),
    .act_i      (is_act),
    .ref_i      (is_ref),
    .bank_i     (cmd_bank),
    .rrd_busy_o (rrd_busy),
    .rfc_busy_o (rfc_busy)
  );

  always_comb begin
    hit          = '0;
    hit[HIT_RCD] = is_col && rcd_busy[cmd_bank];
    hit[HIT_RAS] = (is_pre && ras_busy[cmd_bank]) || (is_prea && (ras_busy != '0));
    hit[HIT_RRD] = is_act && rrd_busy;
    hit[HIT_RC]  = is_act && rc_busy[cmd_bank];
    hit[HIT_RP]  = is_act && rp_busy[cmd_bank];
    hit[HIT_RFC] = (is_act || is_ref) && rfc_busy;
  end

  dtc_rule_select #(.NUM_BANKS(NUM_BANKS)) u_sel (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit_i  (hit),
    .bank_i (cmd_bank),
    .viol_o (viol_valid),
    .rule_o (viol_rule),
    .bank_o (viol_bank)
  );

  a_r12_idle_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept || (cmd_op == CMD_DESEL)) |=> !viol_valid);

  a_r11_flag_follows_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> (viol_valid && (viol_bank == $past(cmd_bank))));
endmodule

// File: tb/sim_dram_cmd_timing_checker.sv
`timescale 1ns/1ps
module sim_dram_cmd_timing_checker;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [2:0] cmd_op = 3'd0;
  logic [2:0] cmd_bank = 3'd0;
  logic       viol_valid;
  logic [2:0] viol_rule;
  logic [2:0] viol_bank;

  int checks = 0;
  int errors = 0;

  // limits: rcd 3, ras 8, rc 11, rrd 2, rp 3, rfc 12
  dram_cmd_timing_checker u0 (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_rcd_cycles (8'd3),
    .cfg_ras_cycles (8'd8),
    .cfg_rc_cycles  (8'd11),
    .cfg_rrd_cycles (8'd2),
    .cfg_rp_cycles  (8'd3),
    .cfg_rfc_cycles (8'd12),
    .cmd_valid      (cmd_valid),
    .cmd_ready      (cmd_ready),
    .cmd_op         (cmd_op),
    .cmd_bank       (cmd_bank),
    .viol_valid     (viol_valid),
    .viol_rule      (viol_rule),
    .viol_bank      (viol_bank)
  );

  always #4 clk = ~clk;

  // opcodes: 0 desel, 1 act, 2 rd, 3 wr, 4 pre, 5 prea, 6 ref, 7 rda
  // vector {valid, op, bank, expected rule}; one entry per cycle from reset
  localparam int NV = 17;
  localparam logic [9:0] VEC [NV] = '{
    {1'b1, 3'd1, 3'd0, 3'd0},  // t0  act b0
    {1'b1, 3'd1, 3'd1, 3'd4},  // t1  act b1, rrd short
    {1'b1, 3'd2, 3'd0, 3'd1},  // t2  rd b0, rcd short
    {1'b1, 3'd2, 3'd0, 3'd0},  // t3  rd b0, rcd exact
    {1'b1, 3'd1, 3'd2, 3'd0},  // t4  act b2
    {1'b1, 3'd4, 3'd0, 3'd2},  // t5  pre b0, ras short
    {1'b1, 3'd0, 3'd0, 3'd0},  // t6  deselect
    {1'b1, 3'd1, 3'd0, 3'd5},  // t7  act b0: rp and rc short, rp wins
    {1'b1, 3'd3, 3'd1, 3'd0},  // t8  wr b1
    {1'b0, 3'd1, 3'd0, 3'd0},  // t9  act b0 with valid low
    {1'b1, 3'd2, 3'd0, 3'd0},  // t10 rd b0, rcd exact after t7 act
    {1'b1, 3'd4, 3'd1, 3'd0},  // t11 pre b1
    {1'b1, 3'd1, 3'd1, 3'd5},  // t12 act b1, rp short, rc exact
    {1'b1, 3'd1, 3'd3, 3'd4},  // t13 act b3, rrd short
    {1'b1, 3'd1, 3'd4, 3'd4},  // t14 act b4, rrd from offending t13
    {1'b1, 3'd6, 3'd0, 3'd0},  // t15 refresh
    {1'b1, 3'd1, 3'd5, 3'd6}   // t16 act b5: rfc wins
  };

  function automatic string tag_of(input logic [2:0] code);
    case (code)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      3'd6: return "R9";
      default: return "R12";
    endcase
  endfunction

  // drive at a falling edge, sample at the next falling edge
  task automatic step(input logic v, input logic [2:0] op, input logic [2:0] bk,
                      input logic [2:0] exp, input string tag);
    cmd_valid = v;
    cmd_op    = op;
    cmd_bank  = bk;
    @(negedge clk);
    checks++;
    if (viol_valid !== (exp != 3'd0) || viol_rule !== exp ||
        (exp != 3'd0 && viol_bank !== bk)) begin
      errors++;
      $display("FAIL %s: op %0d bank %0d got valid %0b rule %0d bank %0d, expected valid %0b rule %0d bank %0d",
               tag, op, bk, viol_valid, viol_rule, viol_bank, exp != 3'd0, exp, bk);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 3'd0, 3'd0, 3'd0, "R12");
  endtask

  task automatic do_reset();
    cmd_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R13: ready low while reset is held, even with a command presented
    rst_n = 1'b0;
    cmd_valid = 1'b1; cmd_op = 3'd1; cmd_bank = 3'd0;
    repeat (3) @(negedge clk);
    checks++;
    if (cmd_ready !== 1'b0 || viol_valid !== 1'b0) begin
      errors++;
      $display("FAIL R13: during reset got ready %0b viol %0b, expected 0 0", cmd_ready, viol_valid);
    end
    cmd_valid = 1'b0;
    rst_n = 1'b1;
    // R1: clean state right after release
    checks++;
    if (cmd_ready !== 1'b1 || viol_valid !== 1'b0 || viol_rule !== 3'd0) begin
      errors++;
      $display("FAIL R1: after reset got ready %0b viol %0b rule %0d, expected 1 0 0",
               cmd_ready, viol_valid, viol_rule);
    end

    // table walk (R2..R6, R9, R10, R11, R12)
    for (int i = 0; i < NV; i++)
      step(VEC[i][9], VEC[i][8:6], VEC[i][5:3], VEC[i][2:0], tag_of(VEC[i][2:0]));

    // R7: precharge-all needs one extra clock before activate
    do_reset();
    step(1'b1, 3'd1, 3'd0, 3'd0, "R7");
    idle(1);
    step(1'b1, 3'd1, 3'd3, 3'd0, "R7");
    idle(8);
    step(1'b1, 3'd5, 3'd0, 3'd0, "R7");
    idle(2);
    step(1'b1, 3'd1, 3'd0, 3'd5, "R7");
    idle(1);
    step(1'b1, 3'd1, 3'd3, 3'd0, "R7");

    // R7: precharge-all while a row is still inside its active time
    do_reset();
    step(1'b1, 3'd1, 3'd6, 3'd0, "R7");
    idle(3);
    step(1'b1, 3'd5, 3'd6, 3'd2, "R7");

    // R8: auto-precharge held until active time elapses (close at t8)
    do_reset();
    step(1'b1, 3'd1, 3'd2, 3'd0, "R8");
    idle(2);
    step(1'b1, 3'd7, 3'd2, 3'd0, "R8");
    idle(6);
    step(1'b1, 3'd1, 3'd2, 3'd5, "R8");
    do_reset();
    step(1'b1, 3'd1, 3'd2, 3'd0, "R8");
    idle(2);
    step(1'b1, 3'd7, 3'd2, 3'd0, "R8");
    idle(7);
    step(1'b1, 3'd1, 3'd2, 3'd0, "R8");

    // R8: late auto-precharge closes in the cycle after the command
    do_reset();
    step(1'b1, 3'd1, 3'd2, 3'd0, "R8");
    idle(8);
    step(1'b1, 3'd7, 3'd2, 3'd0, "R8");
    idle(2);
    step(1'b1, 3'd1, 3'd2, 3'd5, "R8");

    // R9: refresh recovery against refresh and activate
    do_reset();
    step(1'b1, 3'd6, 3'd0, 3'd0, "R9");
    idle(4);
    step(1'b1, 3'd6, 3'd0, 3'd6, "R9");
    idle(10);
    step(1'b1, 3'd1, 3'd0, 3'd6, "R9");
    idle(1);
    step(1'b1, 3'd1, 3'd1, 3'd0, "R9");

    // R13/R12: an activate with valid low does not start cross-bank spacing
    do_reset();
    step(1'b1, 3'd1, 3'd0, 3'd0, "R13");
    step(1'b0, 3'd1, 3'd1, 3'd0, "R13");
    step(1'b1, 3'd1, 3'd1, 3'd0, "R13");

    // R4: same-bank activate inside cycle time, bank reported (R11)
    do_reset();
    step(1'b1, 3'd1, 3'd7, 3'd0, "R4");
    idle(1);
    step(1'b1, 3'd1, 3'd7, 3'd3, "R4");

    // R3/R4/R6 exact boundaries
    do_reset();
    step(1'b1, 3'd1, 3'd0, 3'd0, "R3");
    idle(7);
    step(1'b1, 3'd4, 3'd0, 3'd0, "R3");
    idle(2);
    step(1'b1, 3'd1, 3'd0, 3'd0, "R4");

    cmd_valid = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule